// File: doc/BRIEF.md
# Partitioned Counter-Bank Overflow Interrupt

This block decides the overflow interrupt level for a bank of performance event counters. The bank is split at a programmable boundary index. Counters below the boundary form the guest range. Counters from the boundary up to the implemented count form the upper range, which is reserved for the hypervisor. A dedicated cycle counter sits in the top slot and always belongs to the guest range. Each range has its own master enable: the guest enable gates the lower range and the cycle counter, and the hypervisor enable gates the reserved range.

From the boundary, the implemented count and a nested-virtualization flag, the block derives three registered masks. The first marks the reserved counters. The second marks the counters that the current context may access. The third marks the counters that are actually counting, given each counter's own enable and the master enable of its range. The same partition gates the overflow-status bits, which are first qualified by the per-counter interrupt enables, to form one level-sensitive interrupt.

Every output is registered. Each output settles one clock after its inputs and does not glitch in between. Counter storage and the interrupt controller lie outside this block.

Top module: `pmu_ovf_part`

## Requirements
- R1: While reset is asserted, every output (reserved mask, accessible mask, counting mask and interrupt) reads zero.
- R2: When the nested flag is low, the reserved mask is zero, whatever the boundary value.
- R3: When the nested flag is high and boundary ≤ implemented count N, the reserved mask has bits boundary through N-1 set. A boundary equal to N reserves nothing. A boundary of 0 reserves every implemented event counter, 0 through N-1.
- R4: When the nested flag is high and the boundary exceeds N, the reserved mask is zero.
- R5: The cycle counter at bit 31 is never reserved. It is always implemented and always present in the accessible mask.
- R6: The implemented mask has bits 0 through N-1 plus bit 31. The accessible mask equals the implemented mask when the nested flag is low or the hypervisor-context flag is high. Otherwise it equals the implemented mask with the reserved bits cleared.
- R7: A counter adds to the interrupt only when both its overflow bit and its interrupt-enable bit are set.
- R8: With the guest enable low, only reserved counters can raise the interrupt. With the hypervisor enable low, reserved counters cannot raise it.
- R9: Counting-mask bit i is set only when count-enable bit i is set and the master enable of its range is high. The hypervisor enable governs reserved bits and the guest enable governs all other bits.
- R10: Each output reflects the inputs sampled at the previous rising clock edge. When the inputs are held constant, the interrupt level stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| nested_i | input | 1 | Nested virtualization active |
| hyp_ctx_i | input | 1 | Current context is the hypervisor |
| glb_en_i | input | 1 | Master enable for the guest range and the cycle counter |
| hyp_en_i | input | 1 | Master enable for the reserved range |
| hpmn_i | input | 5 | Boundary index where the reserved range starts |
| impl_n_i | input | 5 | Number N of implemented event counters |
| ovf_i | input | 32 | Overflow-status bit for each counter |
| irq_en_i | input | 32 | Interrupt-enable bit for each counter |
| cnt_en_i | input | 32 | Count-enable bit for each counter |
| resv_mask_o | output | 32 | Counters reserved for the hypervisor |
| acc_mask_o | output | 32 | Counters accessible from the current context |
| cnt_mask_o | output | 32 | Counters that are actually counting |
| irq_o | output | 1 | Level-sensitive overflow interrupt |

## Verification
The partition decode and the interrupt gating act in the same cycle: the boundary value that makes a counter reserved also decides which master enable admits that counter's pending overflow. The bench provokes this by moving the boundary so that a pending counter changes range while exactly one master enable is low, for example counter 2 reserved with the guest enable off, or reserved with the hypervisor enable off. It judges the interrupt level together with the reserved mask and the counting mask taken from the same clock edge. In those cases the interrupt must follow the range the counter was just assigned to. It must not follow the counter's index alone.

// File: rtl/pmu_part_pkg.sv
package pmu_part_pkg;

    // Which master enable governs a counter slot
    typedef enum logic [0:0] {
        GATE_GUEST = 1'b0,
        GATE_HYP   = 1'b1
    } range_sel_e;

endpackage

// File: rtl/pmu_range_dec.sv
module pmu_range_dec #(
    parameter  int EVT_SLOTS = 31,
    localparam int VEC_W     = EVT_SLOTS + 1,
    localparam int IDX_W     = $clog2(EVT_SLOTS + 1),
    localparam int CYC_IDX   = EVT_SLOTS
) (
    input  logic             nested_i,
    input  logic             hyp_ctx_i,
    input  logic [IDX_W-1:0] hpmn_i,
    input  logic [IDX_W-1:0] impl_n_i,
    output logic [VEC_W-1:0] resv_o,
    output logic [VEC_W-1:0] acc_o
);

    logic [VEC_W-1:0] impl;
    logic             split_ok;

    // An out-of-range boundary reserves nothing
    assign split_ok = nested_i && (hpmn_i <= impl_n_i);

    for (genvar g = 0; g < VEC_W; g++) begin : g_slot
        if (g == CYC_IDX) begin : g_cyc
            assign impl[g]   = 1'b1;
            assign resv_o[g] = 1'b0;
        end else begin : g_evt
            assign impl[g]   = (g < int'(impl_n_i));
            assign resv_o[g] = split_ok && (g >= int'(hpmn_i)) && (g < int'(impl_n_i));
        end
    end

    assign acc_o = (nested_i && !hyp_ctx_i) ? (impl & ~resv_o) : impl;

endmodule

// File: rtl/pmu_cnt_gate.sv
module pmu_cnt_gate
    import pmu_part_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic [VEC_W-1:0] cnt_en_i,
    input  logic [VEC_W-1:0] resv_i,
    input  logic             glb_en_i,
    input  logic             hyp_en_i,
    output logic [VEC_W-1:0] cnt_o
);

    for (genvar g = 0; g < VEC_W; g++) begin : g_bit
        range_sel_e sel;
        assign sel      = resv_i[g] ? GATE_HYP : GATE_GUEST;
        assign cnt_o[g] = cnt_en_i[g] && ((sel == GATE_HYP) ? hyp_en_i : glb_en_i);
    end

endmodule

// File: rtl/pmu_irq_eval.sv
module pmu_irq_eval #(
    parameter int VEC_W = 32
) (
    input  logic [VEC_W-1:0] ovf_i,
    input  logic [VEC_W-1:0] irq_en_i,
    input  logic [VEC_W-1:0] resv_i,
    input  logic             glb_en_i,
    input  logic             hyp_en_i,
    output logic             level_o
);

    logic [VEC_W-1:0] pend;
    logic [VEC_W-1:0] guest_keep;
    logic [VEC_W-1:0] hyp_keep;

    assign pend       = ovf_i & irq_en_i;
    assign guest_keep = glb_en_i ? {VEC_W{1'b1}} : resv_i;
    assign hyp_keep   = hyp_en_i ? {VEC_W{1'b1}} : ~resv_i;
    assign level_o    = |(pend & guest_keep & hyp_keep);

endmodule

// File: rtl/pmu_ovf_part.sv
module pmu_ovf_part #(
    parameter  int EVT_SLOTS = 31,
    localparam int VEC_W     = EVT_SLOTS + 1,
    localparam int IDX_W     = $clog2(EVT_SLOTS + 1),
    localparam int CYC_IDX   = EVT_SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nested_i,
    input  logic             hyp_ctx_i,
    input  logic             glb_en_i,
    input  logic             hyp_en_i,
    input  logic [IDX_W-1:0] hpmn_i,
    input  logic [IDX_W-1:0] impl_n_i,
    input  logic [VEC_W-1:0] ovf_i,
    input  logic [VEC_W-1:0] irq_en_i,
    input  logic [VEC_W-1:0] cnt_en_i,
    output logic [VEC_W-1:0] resv_mask_o,
    output logic [VEC_W-1:0] acc_mask_o,
    output logic [VEC_W-1:0] cnt_mask_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [VEC_W-1:0] resv;
        logic [VEC_W-1:0] acc;
        logic [VEC_W-1:0] cnt;
        logic             irq;
    } state_t;

    state_t st_d, st_q;

    logic [VEC_W-1:0] resv_c, acc_c, cnt_c;
    logic             level_c;

    pmu_range_dec #(.EVT_SLOTS(EVT_SLOTS)) u_dec (
        .nested_i (nested_i),
        .hyp_ctx_i(hyp_ctx_i),
        .hpmn_i   (hpmn_i),
        .impl_n_i (impl_n_i),
        .resv_o   (resv_c),
        .acc_o    (acc_c)
    );

    pmu_cnt_gate #(.VEC_W(VEC_W)) u_cnt (
        .cnt_en_i(cnt_en_i),
        .resv_i  (resv_c),
        .glb_en_i(glb_en_i),
        .hyp_en_i(hyp_en_i),
        .cnt_o   (cnt_c)
    );

    pmu_irq_eval #(.VEC_W(VEC_W)) u_irq (
        .ovf_i   (ovf_i),
        .irq_en_i(irq_en_i),
        .resv_i  (resv_c),
        .glb_en_i(glb_en_i),
        .hyp_en_i(hyp_en_i),
        .level_o (level_c)
    );

    always_comb begin
        st_d      = st_q;
        st_d.resv = resv_c;
        st_d.acc  = acc_c;
        st_d.cnt  = cnt_c;
        // level moves only when the computed state differs
        if (level_c != st_q.irq) begin
            st_d.irq = level_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resv_mask_o = st_q.resv;
    assign acc_mask_o  = st_q.acc;
    assign cnt_mask_o  = st_q.cnt;
    assign irq_o       = st_q.irq;

    // ---------------- checks ----------------
    logic [1:0] arm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 2'b00;
        else        arm_q <= {arm_q[0], 1'b1};
    end

    logic [2*IDX_W+3*VEC_W+3:0] in_bus;
    assign in_bus = {nested_i, glb_en_i, hyp_en_i, hyp_ctx_i, hpmn_i, impl_n_i,
                     ovf_i, irq_en_i, cnt_en_i};

    p_resv_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q[0] && !$past(nested_i)) |-> (resv_mask_o == '0));

    p_resv_big_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q[0] && ($past(hpmn_i) > $past(impl_n_i))) |-> (resv_mask_o == '0));

    p_cyc_guest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q[0] |-> (!resv_mask_o[CYC_IDX] && acc_mask_o[CYC_IDX]));

    p_acc_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q[0] && !$past(hyp_ctx_i)) |-> ((acc_mask_o & resv_mask_o) == '0));

    p_irq_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q[0] && irq_o) |-> (($past(ovf_i) & $past(irq_en_i)) != '0));

    p_irq_guest_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q[0] && irq_o && !$past(glb_en_i))
            |-> (($past(ovf_i) & $past(irq_en_i) & resv_mask_o) != '0));

    p_irq_hyp_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q[0] && irq_o && !$past(hyp_en_i))
            |-> (($past(ovf_i) & $past(irq_en_i) & ~resv_mask_o) != '0));

    p_cnt_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q[0] |-> ((cnt_mask_o & ~$past(cnt_en_i)) == '0));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q[1] && ($past(in_bus) == $past(in_bus, 2))) |-> $stable(irq_o));

endmodule

// File: tb/pmu_ovf_part_test.sv
module pmu_ovf_part_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nested, hypctx, gen, hen;
    logic [4:0]  hpmn, nimp;
    logic [31:0] ovf, ien, cen;
    logic [31:0] resv, acc, cnt;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pmu_ovf_part uut (
        .clk(clk), .rst_n(rst_n), .nested_i(nested), .hyp_ctx_i(hypctx),
        .glb_en_i(gen), .hyp_en_i(hen), .hpmn_i(hpmn), .impl_n_i(nimp),
        .ovf_i(ovf), .irq_en_i(ien), .cnt_en_i(cen),
        .resv_mask_o(resv), .acc_mask_o(acc), .cnt_mask_o(cnt), .irq_o(irq)
    );

    typedef struct packed {
        logic        nest, hyp, e, hpme;
        logic [4:0]  b, n;
        logic [31:0] ovf, ien, cen, xresv, xacc, xcnt;
        logic        xirq;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R2 R6 R7: nesting off, nothing reserved
        '{1'b0,1'b0,1'b1,1'b1,5'd2,5'd4,32'h4,32'h4,32'hF,32'h0,32'h8000000F,32'hF,1'b1,4'd2},
        // R3 R7: split 2..3, no enable paired with overflow
        '{1'b1,1'b0,1'b1,1'b1,5'd2,5'd4,32'h4,32'h0,32'hF,32'hC,32'h80000003,32'hF,1'b0,4'd3},
        // R8: guest enable off, reserved counter 2 still raises
        '{1'b1,1'b0,1'b0,1'b1,5'd2,5'd4,32'h80000005,32'h80000005,32'h8000000F,32'hC,32'h80000003,32'hC,1'b1,4'd8},
        // R8: guest enable off, only guest/cycle overflows pending
        '{1'b1,1'b0,1'b0,1'b1,5'd2,5'd4,32'h80000001,32'h80000005,32'h8000000F,32'hC,32'h80000003,32'hC,1'b0,4'd8},
        // R8 R9: hypervisor enable off masks reserved overflow
        '{1'b1,1'b0,1'b1,1'b0,5'd2,5'd4,32'h4,32'h4,32'hF,32'hC,32'h80000003,32'h3,1'b0,4'd9},
        // R5: cycle counter overflow uses guest enable
        '{1'b1,1'b0,1'b1,1'b0,5'd2,5'd4,32'h80000004,32'h80000004,32'hF,32'hC,32'h80000003,32'h3,1'b1,4'd5},
        // R3: boundary zero reserves all event counters
        '{1'b1,1'b0,1'b1,1'b1,5'd0,5'd6,32'h20,32'h20,32'h80000001,32'h3F,32'h80000000,32'h80000001,1'b1,4'd3},
        // R3: boundary equal to N reserves nothing
        '{1'b1,1'b0,1'b1,1'b1,5'd6,5'd6,32'h0,32'hFFFFFFFF,32'h3F,32'h0,32'h8000003F,32'h3F,1'b0,4'd3},
        // R4: boundary above N reserves nothing
        '{1'b1,1'b0,1'b0,1'b1,5'd7,5'd6,32'h20,32'h20,32'h3F,32'h0,32'h8000003F,32'h0,1'b0,4'd4},
        // R6: hypervisor context sees the whole bank
        '{1'b1,1'b1,1'b1,1'b1,5'd1,5'd3,32'h2,32'h2,32'h0,32'h6,32'h80000007,32'h0,1'b1,4'd6},
        // R5: no event counters implemented, cycle counter only
        '{1'b1,1'b0,1'b1,1'b1,5'd0,5'd0,32'h80000000,32'h80000000,32'h80000000,32'h0,32'h80000000,32'h80000000,1'b1,4'd5},
        // R9: widest bank, counter 30 reserved and gated off
        '{1'b1,1'b0,1'b1,1'b0,5'd30,5'd31,32'h40000000,32'hFFFFFFFF,32'hFFFFFFFF,32'h40000000,32'hBFFFFFFF,32'hBFFFFFFF,1'b0,4'd9}
    };

    task automatic check(input string what, input int rq, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, a, e);
        end
    endtask

    task automatic drive(input vec_t v);
        nested = v.nest; hypctx = v.hyp; gen = v.e; hen = v.hpme;
        hpmn = v.b; nimp = v.n; ovf = v.ovf; ien = v.ien; cen = v.cen;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        // R1: reset with inputs that would raise everything
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        check("reset resv", 1, resv, 32'h0);
        check("reset acc",  1, acc,  32'h0);
        check("reset cnt",  1, cnt,  32'h0);
        check("reset irq",  1, {31'b0, irq}, 32'h0);

        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("vec%0d resv", i), int'(VECS[i].rq), resv, VECS[i].xresv);
            check($sformatf("vec%0d acc",  i), int'(VECS[i].rq), acc,  VECS[i].xacc);
            check($sformatf("vec%0d cnt",  i), int'(VECS[i].rq), cnt,  VECS[i].xcnt);
            check($sformatf("vec%0d irq",  i), int'(VECS[i].rq), {31'b0, irq}, {31'b0, VECS[i].xirq});
        end

        // R10: held inputs keep the level; change lands one edge later
        @(negedge clk);
        drive(VECS[2]);
        repeat (3) @(negedge clk);
        check("hold irq", 10, {31'b0, irq}, 32'h1);
        drive(VECS[3]);
        #2;
        check("before edge irq", 10, {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("after edge irq", 10, {31'b0, irq}, 32'h0);

        // R7: overflow and enable on different counters
        drive(VECS[0]);
        ien = 32'h8;
        @(negedge clk);
        check("unpaired irq", 7, {31'b0, irq}, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule